// File: doc/BRIEF.md
# Word-Aligned HDLC Frame Receiver (32-bit Flags and Escapes)

This block sits behind a payload descrambler on a very fast serial link and turns a stream of 32-bit-aligned words back into packets. Frames are bounded by one of four flag words. The two low bits of a flag give the number of pad bytes, 0 to 3, that sit in front of it. A 32-bit escape word protects payload words that would otherwise look like a flag or an escape. Each frame ends with a 32-bit frame check sequence. The receiver removes the escapes, the pad and the check sequence, and it verifies the check sequence.

Payload leaves the block as 32-bit words that keep the byte order of the input, most significant byte first. Each packet is marked with start and end. The final beat carries a count of valid bytes and exactly one status bit: good, check-sequence error or abort. A word moves through a two-word holding stage, because the trailing check sequence can straddle two words and only the closing flag shows how much of the tail is payload.

Top module: `hdlc32_rx_deframer`

## Requirements
- R1: After reset `out_valid` is 0, and words that arrive before the first flag word produce no output. Any flag or abort marks the start of the next frame.
- R2: The four flag words are E781CA34, E781CA35, E781CA36 and E781CA37. Any of them closes the current frame. The payload is delivered in order with the input's most significant byte first in `out_data[31:24]`, and `out_sop` is set on the first beat of the packet.
- R3: The low two bits of the closing flag give the pad byte count p. The pad bytes and the 4 FCS bytes before them are not delivered. The last beat has `out_eop`=1 and `out_nbytes`=4-p (1 to 4), and its valid bytes sit at the top of `out_data`.
- R4: The word EB8DC638 is dropped when it is not itself escaped. The word after it is XORed with 20202020 and treated as data. This holds when the result equals a flag or the escape word, and when the escaped word is E781CA35, E781CA36 or E781CA37.
- R5: EB8DC638 followed by E781CA34 aborts the frame. If the frame has received data, one beat is emitted with `out_eop`=1, `out_abort`=1, `out_nbytes`=0 and `out_sop` set only if no beat of the frame was sent before. The next frame starts right after the abort.
- R6: The FCS is CRC-32: polynomial 04C11DB7, all-ones preset, input shifted in most significant bit first, the complemented value sent most significant byte first. The final beat sets `out_good` when the CRC over data plus FCS equals the residue C704DD7B, and sets `out_fcs_err` otherwise.
- R7: A frame with fewer than two words after unescaping produces no output, and neither do adjacent flags. Such a frame has no payload byte beyond the FCS.
- R8: A data word is delivered one cycle after the second later data word of its frame arrives. The final beat appears one cycle after the closing flag. Beats that are not final have `out_nbytes`=4 and all status bits at 0.
- R9: Cycles with `in_valid`=0 have no effect, and every output beat follows an accepted input word by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Received word |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 32 | Payload bytes, most significant first |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |
| out_nbytes | output | 3 | Valid bytes in beat (0 on abort) |
| out_good | output | 1 | Packet ended with correct FCS |
| out_fcs_err | output | 1 | Packet ended with FCS mismatch |
| out_abort | output | 1 | Packet was aborted |

## Verification
The bench builds the receiver with its default code words: the flag base, the escape word, the XOR mask, the polynomial and the residue. With these defaults the frames it sends are standard ones. Its payload lengths of 1 to 13 bytes cover all four pad values. A forced-escape mode covers escaped flag values, and it also covers an escape followed by a non-zero flag index. Gaps in `in_valid`, aborts after 0, 1 and 4 words, runts and adjacent flags exercise the boundary paths of the two-word holding stage.

// File: rtl/hdlc32_rx_deframer.sv
module hdlc32_rx_deframer #(
  parameter logic [31:0] FLAG_BASE   = 32'hE781CA34,
  parameter logic [31:0] ESC_WORD    = 32'hEB8DC638,
  parameter logic [31:0] XOR_MASK    = 32'h20202020,
  parameter logic [31:0] CRC_POLY    = 32'h04C11DB7,
  parameter logic [31:0] CRC_RESIDUE = 32'hC704DD7B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic [2:0]  out_nbytes,
  output logic        out_good,
  output logic        out_fcs_err,
  output logic        out_abort
);

  logic        in_frame, esc_q, sent_q;
  logic [1:0]  cnt_q;
  logic [31:0] w_new, w_old, crc_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] w,
                                           input logic [2:0] n);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int b = 0; b < 4; b++) begin
      if (b < int'(n)) begin
        for (int k = 0; k < 8; k++) begin
          fb = r[31] ^ w[31 - 8*b - k];
          r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
      end
    end
    return r;
  endfunction

  wire        hit_flag = in_word[31:2] == FLAG_BASE[31:2];
  wire        ev_abort = in_valid && esc_q && (in_word == FLAG_BASE);
  wire        ev_esc   = in_valid && !esc_q && (in_word == ESC_WORD);
  wire        ev_flag  = in_valid && !esc_q && hit_flag;
  wire        ev_data  = in_valid && !ev_abort && !ev_esc && !ev_flag;
  wire [31:0] data_w   = esc_q ? (in_word ^ XOR_MASK) : in_word;
  wire [2:0]  last_n   = 3'd4 - {1'b0, in_word[1:0]};
  wire [31:0] crc_end  = crc_step(crc_q, w_new, last_n);
  wire        fcs_ok   = crc_end == CRC_RESIDUE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame    <= 1'b0;
      esc_q       <= 1'b0;
      sent_q      <= 1'b0;
      cnt_q       <= 2'd0;
      w_new       <= 32'h0;
      w_old       <= 32'h0;
      crc_q       <= '1;
      out_valid   <= 1'b0;
      out_data    <= 32'h0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_nbytes  <= 3'd4;
      out_good    <= 1'b0;
      out_fcs_err <= 1'b0;
      out_abort   <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_nbytes  <= 3'd4;
      out_good    <= 1'b0;
      out_fcs_err <= 1'b0;
      out_abort   <= 1'b0;
      if (in_valid) esc_q <= ev_esc;

      if (ev_data && in_frame) begin
        if (cnt_q == 2'd2) begin
          out_valid <= 1'b1;
          out_data  <= w_old;
          out_sop   <= !sent_q;
          sent_q    <= 1'b1;
        end
        if (cnt_q != 2'd0) crc_q <= crc_step(crc_q, w_new, 3'd4);
        w_old <= w_new;
        w_new <= data_w;
        if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
      end

      if (ev_flag || ev_abort) begin
        in_frame <= 1'b1;
        cnt_q    <= 2'd0;
        sent_q   <= 1'b0;
        crc_q    <= '1;
        if (in_frame && ev_flag && cnt_q == 2'd2) begin
          out_valid   <= 1'b1;
          out_data    <= w_old;
          out_sop     <= !sent_q;
          out_eop     <= 1'b1;
          out_nbytes  <= last_n;
          out_good    <= fcs_ok;
          out_fcs_err <= !fcs_ok;
        end
        if (in_frame && ev_abort && (cnt_q != 2'd0 || sent_q)) begin
          out_valid  <= 1'b1;
          out_data   <= 32'h0;
          out_sop    <= !sent_q;
          out_eop    <= 1'b1;
          out_nbytes <= 3'd0;
          out_abort  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc32_rx_deframer_chk.sv
module hdlc32_rx_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic       out_sop,
  input logic       out_eop,
  input logic [2:0] out_nbytes,
  input logic       out_good,
  input logic       out_fcs_err,
  input logic       out_abort
);

  AST_END_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |-> ($countones({out_good, out_fcs_err, out_abort}) == 1)); // R6

  AST_MID_BEAT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |-> (out_nbytes == 3'd4 && !out_good && !out_fcs_err && !out_abort)); // R8

  AST_LAST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop && !out_abort) |-> (out_nbytes >= 3'd1 && out_nbytes <= 3'd4)); // R3

  AST_ABORT_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_abort) |-> (out_eop && out_nbytes == 3'd0)); // R5

  AST_BEAT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R9

  AST_SOP_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_sop && !out_eop)); // R2

endmodule

bind hdlc32_rx_deframer hdlc32_rx_deframer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_sop(out_sop), .out_eop(out_eop), .out_nbytes(out_nbytes),
  .out_good(out_good), .out_fcs_err(out_fcs_err), .out_abort(out_abort));

// File: tb/hdlc32_rx_deframer_tb.sv
module hdlc32_rx_deframer_tb_top;
  localparam logic [31:0] FLAG = 32'hE781CA34;
  localparam logic [31:0] ESC  = 32'hEB8DC638;
  localparam logic [31:0] MASK = 32'h20202020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = 32'h0;
  logic        out_valid, out_sop, out_eop, out_good, out_fcs_err, out_abort;
  logic [31:0] out_data;
  logic [2:0]  out_nbytes;

  always #2 clk = ~clk;

  hdlc32_rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_nbytes(out_nbytes), .out_good(out_good), .out_fcs_err(out_fcs_err),
    .out_abort(out_abort));

  int          checks = 0, errors = 0, beats = 0;
  bit          done = 1'b0;
  logic [39:0] exp_q[$];
  string       tag_q[$];
  string       ctx = "R1";
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] mask_of(input logic [2:0] n);
    return (n == 3'd0) ? 32'h0 : (32'hFFFF_FFFF << (8 * (4 - int'(n))));
  endfunction

  function automatic logic [31:0] crc_bytes(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[i])
      for (int k = 7; k >= 0; k--)
        c = {c[30:0], 1'b0} ^ ((c[31] ^ b[i][k]) ? 32'h04C11DB7 : 32'h0);
    return c;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [39:0] e, g;
      string t;
      beats++;
      checks++;
      g = {out_data, out_sop, out_eop, out_nbytes, out_good, out_fcs_err, out_abort};
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected beat got %h exp none", ctx, g);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g[39:8] = g[39:8] & mask_of(e[5:3]);
        e[39:8] = e[39:8] & mask_of(e[5:3]);
        if (g !== e) begin
          errors++;
          $display("FAIL %s beat got %h exp %h", t, g, e);
        end
      end
    end
  end

  task automatic put(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 32'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d, input bit s, input bit e, input logic [2:0] n,
                      input bit g, input bit f, input bit a, input string t);
    exp_q.push_back({d, s, e, n, g, f, a});
    tag_q.push_back(t);
  endtask

  task automatic send_frame(input logic [7:0] pl[$], input bit corrupt, input bit gaps,
                            input bit esc_all, input string t);
    logic [7:0]  st[$];
    logic [31:0] fcs, w;
    int p, nb, np;
    st  = pl;
    fcs = ~crc_bytes(pl);
    for (int b = 3; b >= 0; b--) st.push_back(fcs[8*b +: 8]);
    p = (4 - (st.size() % 4)) % 4;
    repeat (p) st.push_back(8'h00);
    if (corrupt) st[0] = st[0] ^ 8'h01;
    np = pl.size();
    nb = (np + 3) / 4;
    for (int k = 0; k < nb; k++)
      push({st[4*k], st[4*k+1], st[4*k+2], st[4*k+3]}, k == 0, k == nb - 1,
           (k == nb - 1) ? 3'(np - 4*k) : 3'd4, (k == nb - 1) && !corrupt,
           (k == nb - 1) && corrupt, 1'b0, t);
    for (int i = 0; i < st.size() / 4; i++) begin
      w = {st[4*i], st[4*i+1], st[4*i+2], st[4*i+3]};
      if (esc_all || w == ESC || w[31:2] == FLAG[31:2]) begin
        put(ESC);
        if (gaps) idle(1);
        put(w ^ MASK);
      end else put(w);
      if (gaps) idle(2);
    end
    put(FLAG | 32'(p));
  endtask

  task automatic rand_pl(input int n, output logic [7:0] pl[$]);
    pl = {};
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      pl.push_back(seed[23:16]);
    end
  endtask

  task automatic quiet(input int mark, input string t);
    idle(3);
    checks++;
    if (beats != mark || exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s extra beats got %0d exp %0d", t, beats - mark, 0);
    end
  endtask

  task automatic drain(input string t);
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing beats got %0d exp 0", t, exp_q.size());
      exp_q = {};
      tag_q = {};
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pl[$];
    int mark;
    idle(3);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset out_valid got %b exp 0", out_valid);
    end
    rst_n = 1'b1;
    idle(1);

    ctx = "R1"; mark = beats;
    put(32'h1111_2222); put(32'h3333_4444); put(32'h5555_6666); put(32'h7777_8888);
    quiet(mark, "R1");
    put(FLAG);

    ctx = "R2";
    for (int n = 1; n <= 8; n++) begin
      rand_pl(n, pl);
      send_frame(pl, 1'b0, 1'b0, 1'b0, (n % 4 == 0) ? "R3" : "R2");
    end
    rand_pl(13, pl);
    send_frame(pl, 1'b0, 1'b1, 1'b0, "R9");
    drain("R2");

    ctx = "R4";
    pl = {8'hE7, 8'h81, 8'hCA, 8'h36, 8'hEB, 8'h8D, 8'hC6, 8'h38, 8'h01, 8'h02};
    send_frame(pl, 1'b0, 1'b0, 1'b0, "R4");
    pl = {8'hC7, 8'hA1, 8'hEA, 8'h15, 8'hAB, 8'hCD, 8'hEF, 8'h01, 8'h77};
    send_frame(pl, 1'b0, 1'b1, 1'b1, "R4");
    drain("R4");

    ctx = "R6";
    rand_pl(11, pl);
    send_frame(pl, 1'b1, 1'b0, 1'b0, "R6");
    rand_pl(6, pl);
    send_frame(pl, 1'b0, 1'b0, 1'b0, "R6");
    drain("R6");

    ctx = "R7"; mark = beats;
    put(FLAG | 32'd2); put(FLAG | 32'd1);
    put(32'hDEAD_BEEF); put(FLAG | 32'd3);
    put(ESC); put(32'h0102_0304); put(FLAG);
    quiet(mark, "R7");

    ctx = "R5";
    push(32'hA0A0_0001, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, "R8");
    push(32'hA0A0_0002, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, "R8");
    push(32'h0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, "R5");
    put(32'hA0A0_0001); put(32'hA0A0_0002); put(32'hA0A0_0003); put(32'hA0A0_0004);
    put(ESC); put(FLAG);
    drain("R5");
    push(32'h0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, "R5");
    put(32'h5A5A_5A5A); put(ESC); put(FLAG);
    drain("R5");
    mark = beats;
    put(ESC); put(FLAG);
    quiet(mark, "R5");
    rand_pl(7, pl);
    send_frame(pl, 1'b0, 1'b0, 1'b0, "R5");
    drain("R5");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule